// File: doc/BRIEF.md
# Priority Output-Port Arbiter with Group Selection

This block decides which source may drive which output port of a packet switch. Each source presents a request that carries three things: a bitmask of the output ports it is allowed to use, a priority bit, and a valid flag. The arbiter gives each waiting source one free port from its mask. It locks that port to the source until the source signals that its end-of-packet marker has gone through. The data path and the address lookup sit outside the block. The block outputs only the grant matrix and, for each source, a busy flag and the index of the port it holds.

Free ports are handed out in ascending order, one arbitration per port, within a single clock cycle. For a given port, waiting high-priority sources always come before low-priority ones. Within one level, a rotating pointer kept for each port gives each source a fair turn. When every port in a source's mask is busy, that source waits and takes nothing from the other sources.

Top module: `out_port_arbiter`

## Requirements
- R1: After reset, no port is granted, every source reads idle with a port index of 0, and every rotation pointer is at source 0.
- R2: A port is granted to source s only if, at the deciding clock edge, the port was free, s had req_valid set and was not busy, and bit s*NPORT+p of req_mask was set.
- R3: Free ports are allocated in ascending index order within a cycle. A source whose mask holds several free ports receives the lowest-numbered one that no earlier port in that cycle has already given away.
- R4: When a free port is wanted by both high-priority sources (req_hi=1) and low-priority sources, it goes to a high-priority one.
- R5: Among sources of the winning priority, a port searches upward with wraparound from its pointer. After a grant, the pointer moves to the source just above the winner.
- R6: A granted port stays with its source on every edge at which that source's eop is low. Changes to the source's req_valid, req_mask or req_hi have no effect on it.
- R7: When eop[s] is high at an edge while s holds a port, the port reads free after that edge. A new grant of that port becomes visible one edge later at the earliest.
- R8: A source holds at most one port. A source that is busy, or whose whole mask is busy, does not prevent other sources from being granted.
- R9: grant bit p*NSRC+s is high exactly when port p belongs to source s, so each port's slice is one-hot or zero. src_port holds the held port's index while src_busy is high, and 0 otherwise. All outputs come straight from registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NSRC | Source has a packet waiting for a port |
| req_hi | input | NSRC | Source's request is high priority |
| req_mask | input | NSRC*NPORT | Allowed ports per source; bit s*NPORT+p allows port p |
| eop | input | NSRC | End-of-packet marker passes on the source's held port this cycle |
| grant | output | NPORT*NSRC | Grant matrix; bit p*NSRC+s means port p belongs to source s |
| src_busy | output | NSRC | Source currently holds a port |
| src_port | output | NSRC*PW | Index of the held port per source, PW = $clog2(NPORT) |

## Verification
The bench builds the block with four sources and three ports. With only three ports, an index never reaches the top of its two-bit field, and under random traffic all ports are often busy, so the no-blocking wait in R8 occurs often. Four sources against one contested port let the rotation pointer make a full wrap. The priority mix lets high requests overtake low ones at that same port. Directed sequences then pin down the ascending port choice, the one-edge release gap, and the pointer order.

// File: rtl/out_port_arbiter.sv
module out_port_arbiter #(
  parameter int NSRC  = 4,
  parameter int NPORT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC-1:0]              req_valid,
  input  logic [NSRC-1:0]              req_hi,
  input  logic [NSRC*NPORT-1:0]        req_mask,
  input  logic [NSRC-1:0]              eop,
  output logic [NPORT*NSRC-1:0]        grant,
  output logic [NSRC-1:0]              src_busy,
  output logic [NSRC*$clog2(NPORT)-1:0] src_port
);
  localparam int SW = (NSRC  > 1) ? $clog2(NSRC)  : 1;
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NPORT-1:0] own_vld, nxt_vld;
  logic [SW-1:0]    own_src [NPORT];
  logic [SW-1:0]    nxt_src [NPORT];
  logic [SW-1:0]    ptr     [NPORT];
  logic [SW-1:0]    nxt_ptr [NPORT];
  logic [NSRC-1:0]  taken;

  always_comb begin
    grant    = '0;
    src_busy = '0;
    src_port = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (own_vld[p]) begin
        grant[p*NSRC + int'(own_src[p])]    = 1'b1;
        src_busy[own_src[p]]                = 1'b1;
        src_port[int'(own_src[p])*PW +: PW] = PW'(p);
      end
    end
  end

  always_comb begin
    int  idx;
    int  win;
    logic found;
    taken = src_busy;
    idx   = 0;
    win   = 0;
    found = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      nxt_vld[p] = own_vld[p];
      nxt_src[p] = own_src[p];
      nxt_ptr[p] = ptr[p];
      if (own_vld[p] && eop[own_src[p]]) nxt_vld[p] = 1'b0;
    end
    for (int p = 0; p < NPORT; p++) begin
      if (!own_vld[p]) begin
        found = 1'b0;
        win   = 0;
        for (int lvl = 0; lvl < 2; lvl++) begin
          for (int k = 0; k < NSRC; k++) begin
            idx = (int'(ptr[p]) + k) % NSRC;
            if (!found && req_valid[idx] && !taken[idx] &&
                req_mask[idx*NPORT + p] && (req_hi[idx] == (lvl == 0))) begin
              found = 1'b1;
              win   = idx;
            end
          end
        end
        if (found) begin
          nxt_vld[p] = 1'b1;
          nxt_src[p] = SW'(win);
          nxt_ptr[p] = (win == NSRC-1) ? '0 : SW'(win + 1);
          taken[win] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld <= '0;
      for (int p = 0; p < NPORT; p++) begin
        own_src[p] <= '0;
        ptr[p]     <= '0;
      end
    end else begin
      own_vld <= nxt_vld;
      for (int p = 0; p < NPORT; p++) begin
        own_src[p] <= nxt_src[p];
        ptr[p]     <= nxt_ptr[p];
      end
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src_chk
    logic [NPORT-1:0] col;
    always_comb for (int p = 0; p < NPORT; p++) col[p] = grant[p*NSRC + s];

    assert_one_port_per_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col) <= 1);

    assert_release_after_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_busy[s] && eop[s]) |=> !src_busy[s]);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
      assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant[p*NSRC + s] && !(req_valid[s] && req_mask[s*NPORT + p]))
        |=> !grant[p*NSRC + s]);

      assert_hold_until_eop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[p*NSRC + s] && !eop[s]) |=> grant[p*NSRC + s]);
    end
  end
endmodule

// File: tb/tb_out_port_arbiter.sv
`timescale 1ns/1ps
module tb_out_port_arbiter;
  localparam int NS = 4;
  localparam int NP = 3;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0]    req_valid = '0;
  logic [NS-1:0]    req_hi = '0;
  logic [NS*NP-1:0] req_mask = '0;
  logic [NS-1:0]    eop = '0;
  logic [NP*NS-1:0] grant;
  logic [NS-1:0]    src_busy;
  logic [NS*PW-1:0] src_port;

  out_port_arbiter #(.NSRC(NS), .NPORT(NP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hi(req_hi),
    .req_mask(req_mask), .eop(eop), .grant(grant), .src_busy(src_busy),
    .src_port(src_port));

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int mv [NP];
  int ms [NP];
  int mptr [NP];
  int nv [NP];
  int nsrc [NP];
  int nptr [NP];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int owner(input int p);
    for (int s = 0; s < NS; s++) if (grant[p*NS+s]) return s;
    return -1;
  endfunction

  function automatic bit mbusy(input int s);
    for (int p = 0; p < NP; p++) if (mv[p] != 0 && ms[p] == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_next();
    bit tk [NS];
    for (int s = 0; s < NS; s++) tk[s] = mbusy(s);
    for (int p = 0; p < NP; p++) begin
      nv[p] = mv[p]; nsrc[p] = ms[p]; nptr[p] = mptr[p];
      if (mv[p] != 0 && eop[ms[p]]) nv[p] = 0;
    end
    for (int p = 0; p < NP; p++) begin
      if (mv[p] == 0) begin
        int w = -1;
        for (int k = 0; k < NS && w < 0; k++) begin
          int c = (mptr[p] + k) % NS;
          if (req_valid[c] && !tk[c] && req_mask[c*NP+p] && req_hi[c]) w = c;
        end
        for (int k = 0; k < NS && w < 0; k++) begin
          int c = (mptr[p] + k) % NS;
          if (req_valid[c] && !tk[c] && req_mask[c*NP+p]) w = c;
        end
        if (w >= 0) begin
          nv[p] = 1; nsrc[p] = w; nptr[p] = (w + 1) % NS; tk[w] = 1'b1;
        end
      end
    end
  endtask

  task automatic compare();
    for (int p = 0; p < NP; p++) begin
      int e = (mv[p] != 0) ? ms[p] : -1;
      chk(owner(p) == e, "R2 R3 R4 R5 grant owner", owner(p), e);
    end
    for (int s = 0; s < NS; s++) begin
      int ep = 0;
      int eb = 0;
      for (int p = 0; p < NP; p++) if (mv[p] != 0 && ms[p] == s) begin eb = 1; ep = p; end
      chk(int'(src_busy[s]) == eb, "R9 busy", int'(src_busy[s]), eb);
      chk(int'(src_port[s*PW +: PW]) == ep, "R9 port index", int'(src_port[s*PW +: PW]), ep);
    end
  endtask

  task automatic cyc();
    model_next();
    @(posedge clk);
    #1;
    for (int p = 0; p < NP; p++) begin mv[p] = nv[p]; ms[p] = nsrc[p]; mptr[p] = nptr[p]; end
    compare();
    @(negedge clk);
  endtask

  task automatic idle_all();
    req_valid = '0; req_hi = '0; req_mask = '0; eop = '1;
    cyc();
    eop = '0;
    cyc();
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin mv[p] = 0; ms[p] = 0; mptr[p] = 0; end
    repeat (3) @(negedge clk);
    chk(grant == '0, "R1 reset grant", int'(grant), 0);
    chk(src_busy == '0, "R1 reset busy", int'(src_busy), 0);
    chk(src_port == '0, "R1 reset index", int'(src_port), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: two low sources rotate on port 0
    req_valid = 4'b0011; req_mask = '0;
    req_mask[0*NP+0] = 1'b1; req_mask[1*NP+0] = 1'b1;
    cyc();
    chk(owner(0) == 0, "R5 first winner", owner(0), 0);
    // R6: inputs of holder change, hold stays
    req_mask[0*NP+0] = 1'b0; req_hi[0] = 1'b1;
    cyc();
    chk(owner(0) == 0, "R6 hold", owner(0), 0);
    eop[0] = 1'b1;
    cyc();
    eop[0] = 1'b0;
    chk(owner(0) == -1, "R7 released", owner(0), -1);
    cyc();
    chk(owner(0) == 1, "R5 R7 next source", owner(0), 1);
    idle_all();

    // R3: lowest free port in group
    req_valid = 4'b0001; req_mask = '0;
    req_mask[0*NP+1] = 1'b1; req_mask[0*NP+2] = 1'b1;
    cyc();
    chk(owner(1) == 0, "R3 lowest port", owner(1), 0);
    chk(int'(src_port[0 +: PW]) == 1, "R3 index", int'(src_port[0 +: PW]), 1);
    // R8: busy holder does not take port 2; another source waits not blocked
    req_valid = 4'b1101;
    req_mask[2*NP+1] = 1'b1;
    req_mask[3*NP+2] = 1'b1;
    cyc();
    chk(owner(2) == 3, "R8 other served", owner(2), 3);
    chk(src_busy[2] == 1'b0, "R8 waiter idle", int'(src_busy[2]), 0);
    idle_all();

    // R4: high beats low on a contested port
    req_valid = 4'b0110; req_hi = 4'b0100; req_mask = '0;
    req_mask[1*NP+0] = 1'b1; req_mask[2*NP+0] = 1'b1;
    cyc();
    chk(owner(0) == 2, "R4 high wins", owner(0), 2);
    idle_all();

    for (int i = 0; i < 4000; i++) begin
      for (int s = 0; s < NS; s++) begin
        req_valid[s] = ($urandom % 4) != 0;
        req_hi[s]    = ($urandom % 3) == 0;
        eop[s]       = ($urandom % 4) == 0;
        for (int p = 0; p < NP; p++) req_mask[s*NP+p] = $urandom % 2;
      end
      cyc();
    end
    idle_all();
    chk(grant == '0, "R7 R8 final drain", int'(grant), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule